// File: doc/BRIEF.md
# Seven-Operand Carry-Save Summation Tree

This block is a purely combinational adder that takes seven unsigned operands and returns their exact total. It does not chain six two-input adders. Instead it passes the operands through a tree of 3:2 carry-save rows. Each row turns three vectors into a sum vector and a carry vector, and no carry ripples between bit positions inside a row.

The tree has five such rows in total:

- The first level compresses operands 0..2 and operands 3..5 side by side.
- Two further rows fold the four resulting vectors together with operand 6.
- A fifth row leaves exactly two vectors.

A single parallel-prefix carry-propagate adder then resolves those two vectors into the result. All intermediate vectors are held at the full result width, so no weight is ever dropped.

The block is intended as a reusable multi-operand summation stage, for example the accumulation of partial terms in a datapath. The operand width is a parameter. The result width is derived from it as the operand width plus three bits, which is enough for seven maximal operands.

Top module: `csa7_sum_tree`

## Requirements
- R1: Each 3:2 cell produces sum = parity of its three input bits and carry = majority of them, so that sum + 2·carry equals the count of ones among the inputs.
- R2: A carry-save row over three vectors yields a sum vector and a carry vector whose arithmetic total equals the total of the three inputs, with every bit position computed independently of its neighbours.
- R3: A row's carry vector is moved one position towards the MSB before it feeds the next stage. Vectors are widened to the result width so that the carry bit shifted out of the top is always zero.
- R4: The final carry-propagate adder adds the last two vectors with a carry-in of zero and returns their exact sum within the result width.
- R5: `sum_o` equals the arithmetic sum of the seven unsigned operands, with result width = OP_W + 3 (11 bits for OP_W = 8).
- R6: With all seven operands at zero, `sum_o` is 0.
- R7: With all seven operands at their maximum (255 for OP_W = 8), `sum_o` is 1785 and no bit is lost.
- R8: With exactly one operand at its maximum and the rest zero, `sum_o` equals that maximum (255) whichever of the seven inputs carries it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op0_i | input | OP_W | Operand 0, unsigned |
| op1_i | input | OP_W | Operand 1, unsigned |
| op2_i | input | OP_W | Operand 2, unsigned |
| op3_i | input | OP_W | Operand 3, unsigned |
| op4_i | input | OP_W | Operand 4, unsigned |
| op5_i | input | OP_W | Operand 5, unsigned |
| op6_i | input | OP_W | Operand 6, unsigned |
| sum_o | output | OP_W+3 | Full-precision sum of the seven operands |

## Verification
Whenever the inputs change, the embedded assertions check the local arithmetic identities:

- the count identity of every 3:2 cell;
- the conservation of value across each carry-save row;
- the absence of any carry pushed past the top of a widened vector;
- the exactness of the prefix adder;
- the equality of the final output with the seven-operand total.

Only the bench scenarios show that specific totals come out right. These are zero, the all-maximum total of 1785, a lone maximum placed in each slot, full sweeps of one slot against saturated neighbours, and random mixes.

// File: rtl/csa7_pkg.sv
package csa7_pkg;
  localparam int unsigned NUM_OPS = 7;

  function automatic int unsigned res_width(input int unsigned op_w);
    return op_w + $clog2(NUM_OPS);
  endfunction
endpackage

// File: rtl/csa_cell.sv
module csa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o,
  output logic c_o
);
  logic [1:0] ones;

  always_comb begin
    s_o  = x_i ^ y_i ^ z_i;
    c_o  = (x_i & y_i) | (z_i & (x_i ^ y_i));
    ones = {1'b0, x_i} + {1'b0, y_i} + {1'b0, z_i};
    AST_CELL_COUNT: assert ({c_o, s_o} == ones) else $error("cell count mismatch"); // R1
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] c_raw;
  logic [W+1:0] in_total;
  logic [W+1:0] out_total;

  for (genvar b = 0; b < W; b++) begin : g_bit
    csa_cell u_cell (
      .x_i (x_i[b]),
      .y_i (y_i[b]),
      .z_i (z_i[b]),
      .s_o (sum_o[b]),
      .c_o (c_raw[b])
    );
  end

  // carry weighs one position more than the sum bit it came from
  assign carry_o = {c_raw[W-2:0], 1'b0};

  always_comb begin
    in_total  = {2'b0, x_i} + {2'b0, y_i} + {2'b0, z_i};
    out_total = {2'b0, sum_o} + {1'b0, c_raw, 1'b0};
    AST_ROW_CONSERVE: assert (out_total == in_total) else $error("row value changed"); // R2
    AST_NO_CARRY_LOSS: assert (c_raw[W-1] == 1'b0) else $error("carry shifted out"); // R3
  end
endmodule

// File: rtl/cpa_prefix.sv
module cpa_prefix #(
  parameter int unsigned W = 11
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] gen_b, prop_b;
  logic [W-1:0] g_cur, p_cur, g_nxt, p_nxt;
  logic [W-1:0] ref_sum;

  always_comb begin
    gen_b  = a_i & b_i;
    prop_b = a_i ^ b_i;
    g_cur  = gen_b;
    p_cur  = prop_b;
    for (int d = 1; d < int'(W); d = d * 2) begin
      g_nxt = g_cur;
      p_nxt = p_cur;
      for (int i = d; i < int'(W); i++) begin
        g_nxt[i] = g_cur[i] | (p_cur[i] & g_cur[i-d]);
        p_nxt[i] = p_cur[i] & p_cur[i-d];
      end
      g_cur = g_nxt;
      p_cur = p_nxt;
    end
    s_o[0] = prop_b[0];
    for (int i = 1; i < int'(W); i++) begin
      s_o[i] = prop_b[i] ^ g_cur[i-1];
    end
    ref_sum = a_i + b_i;
    AST_CPA_EXACT: assert (s_o == ref_sum) else $error("prefix adder mismatch"); // R4
  end
endmodule

// File: rtl/csa7_sum_tree.sv
module csa7_sum_tree
  import csa7_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [OP_W-1:0]               op0_i,
  input  logic [OP_W-1:0]               op1_i,
  input  logic [OP_W-1:0]               op2_i,
  input  logic [OP_W-1:0]               op3_i,
  input  logic [OP_W-1:0]               op4_i,
  input  logic [OP_W-1:0]               op5_i,
  input  logic [OP_W-1:0]               op6_i,
  output logic [res_width(OP_W)-1:0]    sum_o
);
  localparam int unsigned RES_W = res_width(OP_W);
  localparam int unsigned PAD_W = RES_W - OP_W;

  logic [RES_W-1:0] ext [NUM_OPS];
  logic [RES_W-1:0] s_l1a, c_l1a, s_l1b, c_l1b;
  logic [RES_W-1:0] s_l2, c_l2, s_l3, c_l3;
  logic [RES_W-1:0] s_fin, c_fin;
  logic [RES_W-1:0] ref_total;

  assign ext[0] = {{PAD_W{1'b0}}, op0_i};
  assign ext[1] = {{PAD_W{1'b0}}, op1_i};
  assign ext[2] = {{PAD_W{1'b0}}, op2_i};
  assign ext[3] = {{PAD_W{1'b0}}, op3_i};
  assign ext[4] = {{PAD_W{1'b0}}, op4_i};
  assign ext[5] = {{PAD_W{1'b0}}, op5_i};
  assign ext[6] = {{PAD_W{1'b0}}, op6_i};

  // level 1: two independent rows
  csa_row #(.W(RES_W)) u_row_l1a (
    .x_i(ext[0]), .y_i(ext[1]), .z_i(ext[2]), .sum_o(s_l1a), .carry_o(c_l1a));
  csa_row #(.W(RES_W)) u_row_l1b (
    .x_i(ext[3]), .y_i(ext[4]), .z_i(ext[5]), .sum_o(s_l1b), .carry_o(c_l1b));

  // level 2: fold four vectors plus operand 6
  csa_row #(.W(RES_W)) u_row_l2 (
    .x_i(s_l1a), .y_i(c_l1a), .z_i(s_l1b), .sum_o(s_l2), .carry_o(c_l2));
  csa_row #(.W(RES_W)) u_row_l3 (
    .x_i(c_l1b), .y_i(ext[6]), .z_i(s_l2), .sum_o(s_l3), .carry_o(c_l3));

  // final row leaves two vectors
  csa_row #(.W(RES_W)) u_row_fin (
    .x_i(c_l2), .y_i(s_l3), .z_i(c_l3), .sum_o(s_fin), .carry_o(c_fin));

  cpa_prefix #(.W(RES_W)) u_cpa (
    .a_i(s_fin), .b_i(c_fin), .s_o(sum_o));

  always_comb begin
    ref_total = '0;
    for (int k = 0; k < int'(NUM_OPS); k++) begin
      ref_total = ref_total + ext[k];
    end
    AST_TOTAL_EXACT: assert (sum_o == ref_total) else $error("tree total mismatch"); // R5
  end
endmodule

// File: tb/csa7_sum_tree_tb.sv
`timescale 1ns/1ps
module csa7_sum_tree_tb_top;
  localparam int OP_W  = 8;
  localparam int RES_W = OP_W + 3;
  localparam int MAXV  = (1 << OP_W) - 1;

  logic clk;
  logic rst_n;
  logic [OP_W-1:0]  ops [7];
  logic [RES_W-1:0] sum_o;
  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  csa7_sum_tree #(.OP_W(OP_W)) dut_i (
    .op0_i(ops[0]), .op1_i(ops[1]), .op2_i(ops[2]), .op3_i(ops[3]),
    .op4_i(ops[4]), .op5_i(ops[5]), .op6_i(ops[6]), .sum_o(sum_o));

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=<done>", cycles);
      finish_run();
    end
  end

  task automatic apply_and_check(input string tag);
    int expv = 0;
    @(posedge clk);
    #0.5;
    for (int k = 0; k < 7; k++) expv += int'(ops[k]);
    @(negedge clk);
    n_checks++;
    if (int'(sum_o) != expv) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, sum_o, expv);
    end
  endtask

  task automatic fill(input int v);
    for (int k = 0; k < 7; k++) ops[k] = OP_W'(v);
  endtask

  initial begin
    rst_n = 1'b0;
    fill(0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R6: zero operands
    fill(0);
    apply_and_check("R6 all zero");
    if (sum_o != '0) begin n_fail++; $display("FAIL R6: actual=%0d expected=0", sum_o); end
    n_checks++;

    // R7: all maximal, expect 1785
    fill(MAXV);
    apply_and_check("R7 all max");
    n_checks++;
    if (int'(sum_o) != 7 * MAXV) begin
      n_fail++;
      $display("FAIL R7: actual=%0d expected=%0d", sum_o, 7 * MAXV);
    end

    // R8: lone maximum in each slot
    for (int k = 0; k < 7; k++) begin
      fill(0);
      ops[k] = OP_W'(MAXV);
      apply_and_check("R8 single max");
      n_checks++;
      if (int'(sum_o) != MAXV) begin
        n_fail++;
        $display("FAIL R8 slot %0d: actual=%0d expected=%0d", k, sum_o, MAXV);
      end
    end

    // R1 R2 R3: first-level row carries only (ops 0..2 busy)
    fill(0);
    ops[0] = 8'hFF; ops[1] = 8'hFF; ops[2] = 8'hFF;
    apply_and_check("R1 R2 row l1a carries");
    fill(0);
    ops[3] = 8'hAA; ops[4] = 8'h55; ops[5] = 8'hFF; ops[6] = 8'h01;
    apply_and_check("R2 R3 row l1b with op6");

    // R3 R4 R5: sweep each slot fully against saturated neighbours
    for (int k = 0; k < 7; k++) begin
      for (int v = 0; v <= MAXV; v++) begin
        fill(MAXV);
        ops[k] = OP_W'(v);
        apply_and_check("R3 R4 R5 slot sweep");
      end
    end

    // R5: sweep against zero neighbours with a walking companion
    for (int v = 0; v <= MAXV; v++) begin
      fill(0);
      ops[v % 7] = OP_W'(v);
      ops[6 - (v % 7)] = OP_W'(MAXV - v);
      apply_and_check("R5 pair sweep");
    end

    // R2 R4 R5: random mixes
    for (int n = 0; n < 2000; n++) begin
      for (int k = 0; k < 7; k++) ops[k] = OP_W'($urandom);
      apply_and_check("R2 R4 R5 random");
    end

    finish_run();
  end
endmodule